// File: doc/BRIEF.md
# Class-Based Memory Access Arbiter

This block decides which of several initiator queues may use a single memory port. The queues are split evenly into three traffic classes. Each class carries its own settings: a one-hot mask that marks one of its queues as urgent, a run length that lets a winner issue several transactions in a row, and a mode bit. The mode bit decides whether a burst may compete at once, or only after every beat of it has been buffered.

The grant is a registered one-hot vector. A holder keeps the grant until the memory side signals the end of a transaction on `done_i`. At that point the holder either continues its run or arbitration reopens. While nothing is granted, arbitration runs on every cycle. Timing, address mapping and data storage sit outside the block.

Top module: `cma_arb_top`

## Requirements
- R1: `grant_o` is all zero after reset and is never more than one-hot.
- R2: Queue i belongs to class i / QPC. At an arbitration point, a class wins only if no lower-numbered class has an eligible queue: class 0 beats class 1, and class 1 beats class 2.
- R3: Bit i of `cfg_hp_i` marks queue i as the urgent queue of its class, with at most one bit set per class. When that queue is eligible at an arbitration point and its class wins, it gets the grant.
- R4: When the class's urgent queue is not eligible, the remaining eligible queues of the class are searched in rising index order, wrapping around. The search starts just after the class's last granted queue, including a grant to the urgent queue. After reset the search starts at the class's first queue.
- R5: The run-length field for class c is `cfg_xcnt_i[c*CW +: CW]`, with value N. A queue granted in class c keeps the grant for up to N+1 completed transactions while its request stays high. N = 0 gives a single transaction.
- R6: If the holder's request is low in a cycle with `done_i` high, the run ends and arbitration reopens in that cycle, even when transactions remain in the run.
- R7: When `cfg_wait_full_i[c]` is 1, a requesting queue of class c is eligible only if its buffered-beat count (`beats_buf_i[i*LW +: LW]`) is at least its burst length (`burst_len_i[i*LW +: LW]`). When the bit is 0, both counts are ignored.
- R8: A non-zero grant changes only on the clock edge that ends a cycle with `done_i` high. While the grant is zero, `done_i` has no effect, and an eligible request is granted on the next edge.
- R9: The run length is sampled when the grant is issued. Changes to `cfg_xcnt_i`, `cfg_hp_i` or `cfg_wait_full_i` during a run do not alter that run, and take effect at the next arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3*QPC | Request, one bit per queue |
| burst_len_i | input | 3*QPC*LW | Beats in the pending burst, per queue |
| beats_buf_i | input | 3*QPC*LW | Beats already buffered, per queue |
| cfg_hp_i | input | 3*QPC | Urgent-queue mask, one-hot within each class |
| cfg_xcnt_i | input | 3*CW | Per-class run length minus one |
| cfg_wait_full_i | input | 3 | Per-class gate: compete only with a fully buffered burst |
| done_i | input | 1 | Current transaction completes this cycle |
| grant_o | output | 3*QPC | One-hot grant, or zero when idle |

## Verification
The hardest case to reach is a multi-transaction run whose configuration changes partway through. The run must keep the length it sampled, and the new urgent-queue and gating settings must apply only at the next arbitration point. A held request also has to drop on exactly the cycle that `done_i` rises. To reach these cases, the stimulus changes the configuration on random cycles while requests stay sticky and run lengths are non-zero. A behavioural model tracks the expected grant and compares it with the design on every clock. A separate phase enables fully-buffered gating while beat counts move around the burst length, so queues cross the eligibility threshold in both directions.

// File: rtl/cma_pkg.sv
package cma_pkg;
  localparam int NCLS = 3;
  typedef logic [1:0] cls_idx_t;
endpackage

// File: rtl/cma_class_pick.sv
module cma_class_pick #(
  parameter int QPC = 4,
  parameter int LW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QPC-1:0]    req_i,
  input  logic [QPC*LW-1:0] blen_i,
  input  logic [QPC*LW-1:0] bbuf_i,
  input  logic [QPC-1:0]    hp_i,
  input  logic              wait_full_i,
  input  logic              take_i,
  output logic              any_o,
  output logic [QPC-1:0]    sel_o
);
  localparam int PW = (QPC > 1) ? $clog2(QPC) : 1;

  logic [QPC-1:0] elig, hp_elig, rr_elig, hp_sel, rr_sel;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic           ptr_en;

  // per-queue eligibility with optional full-burst gating
  for (genvar q = 0; q < QPC; q++) begin : g_elig
    assign elig[q] = req_i[q] &
                     (~wait_full_i | (bbuf_i[q*LW +: LW] >= blen_i[q*LW +: LW]));
  end

  assign hp_elig = elig & hp_i;
  assign rr_elig = elig & ~hp_i;
  assign hp_sel  = hp_elig & (~hp_elig + 1'b1);

  // rotating search starting after the last granted queue
  always_comb begin
    int  idx;
    logic found;
    rr_sel = '0;
    found  = 1'b0;
    for (int k = 1; k <= QPC; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= QPC) idx = idx - QPC;
      if (!found && rr_elig[idx]) begin
        rr_sel[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign any_o = |elig;
  assign sel_o = (|hp_elig) ? hp_sel : rr_sel;

  assign ptr_en = take_i & any_o;

  always_comb begin
    ptr_d = ptr_q;
    for (int q = 0; q < QPC; q++) begin
      if (sel_o[q]) ptr_d = PW'(q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= PW'(QPC - 1);
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/cma_seq_ctrl.sv
module cma_seq_ctrl #(
  parameter int NQ = 12,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] req_i,
  input  logic          done_i,
  input  logic [NQ-1:0] win_i,
  input  logic [CW-1:0] win_cnt_i,
  output logic [NQ-1:0] grant_o,
  output logic          open_o
);
  logic [NQ-1:0] grant_q, grant_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          holder_req, idle, en;

  assign idle       = (grant_q == '0);
  assign holder_req = |(grant_q & req_i);
  assign open_o     = idle | (done_i & ((rem_q == '0) | ~holder_req));

  always_comb begin
    grant_d = grant_q;
    rem_d   = rem_q;
    if (open_o) begin
      grant_d = win_i;
      rem_d   = win_cnt_i;
    end else if (done_i) begin
      rem_d   = rem_q - 1'b1;
    end
  end

  assign en = open_o | done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      rem_q   <= '0;
    end else if (en) begin
      grant_q <= grant_d;
      rem_q   <= rem_d;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/cma_arb_top.sv
module cma_arb_top
  import cma_pkg::*;
#(
  parameter int QPC = 4,
  parameter int LW  = 5,
  parameter int CW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCLS*QPC-1:0]    req_i,
  input  logic [NCLS*QPC*LW-1:0] burst_len_i,
  input  logic [NCLS*QPC*LW-1:0] beats_buf_i,
  input  logic [NCLS*QPC-1:0]    cfg_hp_i,
  input  logic [NCLS*CW-1:0]     cfg_xcnt_i,
  input  logic [NCLS-1:0]        cfg_wait_full_i,
  input  logic                   done_i,
  output logic [NCLS*QPC-1:0]    grant_o
);
  localparam int NQ = NCLS * QPC;

  logic [NCLS-1:0] cls_any, cls_win;
  logic [NQ-1:0]   cls_sel, win_vec;
  logic [CW-1:0]   win_cnt;
  cls_idx_t        win_cls;
  logic            open;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    cma_class_pick #(.QPC(QPC), .LW(LW)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i[c*QPC +: QPC]),
      .blen_i     (burst_len_i[c*QPC*LW +: QPC*LW]),
      .bbuf_i     (beats_buf_i[c*QPC*LW +: QPC*LW]),
      .hp_i       (cfg_hp_i[c*QPC +: QPC]),
      .wait_full_i(cfg_wait_full_i[c]),
      .take_i     (open & cls_win[c]),
      .any_o      (cls_any[c]),
      .sel_o      (cls_sel[c*QPC +: QPC])
    );
    assign win_vec[c*QPC +: QPC] = cls_sel[c*QPC +: QPC] & {QPC{cls_win[c]}};
  end

  // fixed class order: lower index first
  always_comb begin
    logic taken;
    cls_win = '0;
    win_cls = '0;
    taken   = 1'b0;
    for (int c = 0; c < NCLS; c++) begin
      if (!taken && cls_any[c]) begin
        cls_win[c] = 1'b1;
        win_cls    = cls_idx_t'(c);
        taken      = 1'b1;
      end
    end
  end

  assign win_cnt = cfg_xcnt_i[win_cls*CW +: CW];

  cma_seq_ctrl #(.NQ(NQ), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .done_i   (done_i),
    .win_i    (win_vec),
    .win_cnt_i(win_cnt),
    .grant_o  (grant_o),
    .open_o   (open)
  );
endmodule

// File: rtl/cma_arb_chk.sv
module cma_arb_chk
  import cma_pkg::*;
#(
  parameter int QPC = 4,
  parameter int LW  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCLS*QPC-1:0]    req_i,
  input logic [NCLS*QPC*LW-1:0] burst_len_i,
  input logic [NCLS*QPC*LW-1:0] beats_buf_i,
  input logic [NCLS*QPC-1:0]    cfg_hp_i,
  input logic [NCLS-1:0]        cfg_wait_full_i,
  input logic                   done_i,
  input logic [NCLS*QPC-1:0]    grant_o
);
  localparam int NQ = NCLS * QPC;

  logic [NQ-1:0]  full_ok;
  logic [QPC-1:0] hp0_req;

  for (genvar i = 0; i < NQ; i++) begin : g_ok
    assign full_ok[i] = ~cfg_wait_full_i[i / QPC] |
                        (beats_buf_i[i*LW +: LW] >= burst_len_i[i*LW +: LW]);
  end

  assign hp0_req = cfg_hp_i[QPC-1:0] & req_i[QPC-1:0];

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_hold_without_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && !done_i) |=> $stable(grant_o));

  assert_grant_was_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o == '0) || done_i) |=> ((grant_o & $past(req_i)) == grant_o));

  assert_urgent_class0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o == '0) && ($countones(cfg_hp_i[QPC-1:0]) == 1) && (hp0_req != '0)
     && !cfg_wait_full_i[0]) |=> (grant_o[QPC-1:0] == $past(hp0_req)));

  assert_full_burst_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0) |=> ((grant_o & ~$past(full_ok)) == '0));
endmodule

bind cma_arb_top cma_arb_chk #(.QPC(QPC), .LW(LW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_i          (req_i),
  .burst_len_i    (burst_len_i),
  .beats_buf_i    (beats_buf_i),
  .cfg_hp_i       (cfg_hp_i),
  .cfg_wait_full_i(cfg_wait_full_i),
  .done_i         (done_i),
  .grant_o        (grant_o)
);

// File: tb/tb_cma_arb_top.sv
module tb_cma_arb_top;
  localparam int QPC = 4;
  localparam int LW  = 5;
  localparam int CW  = 3;
  localparam int NC  = 3;
  localparam int NQ  = NC * QPC;

  logic               clk, rst_n, done;
  logic [NQ-1:0]      req, hp, grant;
  logic [NQ*LW-1:0]   blen, bbuf;
  logic [NC*CW-1:0]   xcnt;
  logic [NC-1:0]      wfull;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag;

  int m_grant, m_rem;
  int m_ptr [NC];

  cma_arb_top #(.QPC(QPC), .LW(LW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .burst_len_i(blen),
    .beats_buf_i(bbuf), .cfg_hp_i(hp), .cfg_xcnt_i(xcnt),
    .cfg_wait_full_i(wfull), .done_i(done), .grant_o(grant));

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic bit elig(int i);
    int bl, bb;
    bl = int'(blen[i*LW +: LW]);
    bb = int'(bbuf[i*LW +: LW]);
    return req[i] && (!wfull[i / QPC] || bb >= bl);
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_grant = -1;
      m_rem   = 0;
      for (int c = 0; c < NC; c++) m_ptr[c] = QPC - 1;
    end else begin
      bit arb;
      arb = (m_grant < 0) || (done && (m_rem == 0 || !req[m_grant]));
      if (!arb) begin
        if (done) m_rem = m_rem - 1;
      end else begin
        m_grant = -1;
        for (int c = 0; c < NC; c++) begin
          int w;
          w = -1;
          if (m_grant < 0) begin
            for (int q = 0; q < QPC; q++)
              if (w < 0 && hp[c*QPC+q] && elig(c*QPC+q)) w = q;
            for (int k = 1; k <= QPC; k++) begin
              int i;
              i = (m_ptr[c] + k) % QPC;
              if (w < 0 && !hp[c*QPC+i] && elig(c*QPC+i)) w = i;
            end
            if (w >= 0) begin
              m_grant  = c*QPC + w;
              m_rem    = int'(xcnt[c*CW +: CW]);
              m_ptr[c] = w;
            end
          end
        end
      end
    end
  end

  task automatic check(string t, logic [NQ-1:0] act, logic [NQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [NQ-1:0] exp_grant();
    return (m_grant < 0) ? '0 : (NQ'(1) << m_grant);
  endfunction

  task automatic rand_hp();
    hp = '0;
    for (int c = 0; c < NC; c++)
      if ($urandom_range(3) != 0) hp[c*QPC + int'($urandom_range(QPC-1))] = 1'b1;
  endtask

  // one cycle: check at negedge, then drive new inputs
  task automatic step(logic [NQ-1:0] req_mask, bit churn);
    @(negedge clk);
    check(tag, grant, exp_grant());
    checks++;
    if ($countones(grant) > 1) begin
      errors++;
      $display("FAIL R1: grant actual %b expected at most one bit", grant);
    end
    for (int i = 0; i < NQ; i++) begin
      if ($urandom_range(7) == 0) req[i] = ~req[i];
      if ($urandom_range(3) == 0) blen[i*LW +: LW] = LW'($urandom_range(8, 1));
      if ($urandom_range(1) == 0) bbuf[i*LW +: LW] = LW'($urandom_range(9));
    end
    req  = req & req_mask;
    done = (grant != '0) ? ($urandom_range(1) == 1) : ($urandom_range(4) == 0);
    if (churn && $urandom_range(9) == 0) begin
      xcnt  = NC*CW'($urandom);
      wfull = NC'($urandom);
      rand_hp();
    end
  endtask

  initial begin
    rst_n = 0; done = 0; req = '0; hp = '0; blen = '0; bbuf = '0;
    xcnt = '0; wfull = '0;
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    check(tag, grant, '0);
    rst_n = 1;

    // R4 R6: one class only, no urgent queue, single transactions
    tag = "R4 R6 round-robin";
    for (int n = 0; n < 2000; n++) step({4'hF, 8'h00}, 0);

    // R2 R3 R5: all classes, urgent queues and runs
    tag = "R2 R3 R5 priority and runs";
    xcnt = {3'd2, 3'd5, 3'd3};
    rand_hp();
    for (int n = 0; n < 3000; n++) step('1, 0);

    // R7: fully buffered gating in every class
    tag = "R7 burst gating";
    wfull = 3'b111;
    xcnt  = {3'd1, 3'd0, 3'd2};
    for (int n = 0; n < 3000; n++) step('1, 0);

    // R8 R9: configuration churn during runs
    tag = "R8 R9 config churn";
    xcnt = {3'd7, 3'd6, 3'd4};
    for (int n = 0; n < 4000; n++) step('1, 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule